// File: doc/BRIEF.md
# Receive-Overrun Guard for a USB Endpoint DMA Path

This block sits on the receive side of a USB endpoint. On one side is the packet receive engine, which delivers bytes with a valid strobe and an end-of-packet marker. On the other side is a memory-write DMA port. Bytes pass through a small holding FIFO on their way to memory. The block watches each packet for two overrun causes:

- **Oversized packet:** the packet carries more bytes than the endpoint's maximum packet size.
- **Memory latency:** the DMA side stalls while the holding FIFO is already full.

For each packet the block decides three things: which bytes reach memory, whether a buffer-descriptor status writeback is requested (and with which PID and byte count), and whether the token-done and DMA-error interrupts fire.

The response depends on the cause and on the host/device mode bit:

- **Oversized packet:** the packet is clipped to the maximum packet size and reported normally, with that size as its length.
- **Latency error in host mode:** reported with the all-ones PID marker.
- **Latency error in device mode:** dropped silently, since a retry is expected.

Any overrun sets a sticky error bit. Software clears that bit with a write-one-to-clear strobe. Both interrupts pass through enable masks.

Top module: `ep_ovr_guard`

## Requirements
- R1: A packet with no overrun forwards every byte to the DMA port in arrival order, then requests a writeback carrying the received token PID and the number of bytes stored, and leaves the error bit clear.
- R2: When a packet holds more bytes than `max_pkt`, exactly `max_pkt` bytes are forwarded and every later byte of that packet is discarded (a `max_pkt` of 0 forwards nothing).
- R3: On an oversized packet, the writeback PID is the received token PID, the writeback length equals `max_pkt`, the token-done event fires, and the error bit is set.
- R4: A latency error is declared when a byte is valid while `dma_rdy` is low and the 4-entry holding FIFO is full. That byte and every later byte of the packet are dropped.
- R5: On a latency error with `host_mode` = 1, a writeback is requested with PID 4'b1111 and a length equal to the bytes actually stored, and the token-done event fires.
- R6: On a latency error with `host_mode` = 0, no writeback is requested and no token-done event fires, but the error bit is set.
- R7: When one packet meets both overrun conditions, the latency behaviour for the current mode is applied.
- R8: The error bit `dma_err_sts` is sticky: once set by any overrun, it stays at 1 until it is cleared.
- R9: A cycle with `err_clr_we` = 1 and `err_clr_bit` = 1 clears the error bit. With `err_clr_bit` = 0 the strobe has no effect. If a set and a clear fall in the same cycle, the set wins.
- R10: `err_irq` equals the error bit ANDed with both `int_en_err` and `err_en_dma`. `tok_irq` is the token-done event ANDed with `int_en_tok`.
- R11: Reset clears all outputs. `wb_req`, `wb_pid`, `wb_len` and `tok_irq` update on the clock edge that samples the end-of-packet byte, and `wb_req` lasts one cycle per packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | DATA_W | Receive byte |
| rx_eop | input | 1 | Marks the last byte of a packet (qualified by rx_valid) |
| rx_pid | input | PID_W | Token PID of the current packet |
| max_pkt | input | LEN_W | Endpoint maximum packet size in bytes |
| host_mode | input | 1 | 1 = host, 0 = device |
| dma_rdy | input | 1 | DMA port accepts a byte this cycle |
| dma_valid | output | 1 | Holding FIFO offers a byte |
| dma_data | output | DATA_W | Byte offered to memory |
| int_en_tok | input | 1 | Token-done interrupt enable |
| int_en_err | input | 1 | Error interrupt enable |
| err_en_dma | input | 1 | DMA error enable mask |
| err_clr_we | input | 1 | Status register write strobe |
| err_clr_bit | input | 1 | Write data for the error bit (1 clears) |
| wb_req | output | 1 | One-cycle descriptor writeback request |
| wb_pid | output | PID_W | PID field for the writeback |
| wb_len | output | LEN_W | Byte count for the writeback |
| tok_irq | output | 1 | Gated token-done interrupt pulse |
| err_irq | output | 1 | Gated DMA error interrupt |
| dma_err_sts | output | 1 | Sticky DMA error status bit |

## Verification
The hardest situation to reach is a packet that meets both overrun conditions on the same byte. That byte must arrive when the stored count has just reached `max_pkt` and the holding FIFO is also full under a stalled DMA port.

The stimulus reaches it by holding `dma_rdy` low for the whole packet and setting `max_pkt` equal to the FIFO depth. The fifth byte then trips both conditions at once, and both modes are run this way.

A second hard case is a set and a clear landing on the same cycle. The bench raises the clear strobe on exactly the cycle of an oversized packet's end-of-packet byte.

// File: rtl/ep_ovr_pkg.sv
package ep_ovr_pkg;

  // Per-packet verdict, decided on the end-of-packet byte.
  typedef enum logic [1:0] {
    OC_CLEAN    = 2'd0,
    OC_OVERSIZE = 2'd1,
    OC_LAT_HOST = 2'd2,
    OC_LAT_DEV  = 2'd3
  } pkt_outcome_e;

  function automatic logic is_error(input pkt_outcome_e oc);
    return oc != OC_CLEAN;
  endfunction

  function automatic logic wants_writeback(input pkt_outcome_e oc);
    return oc != OC_LAT_DEV;
  endfunction

endpackage

// File: rtl/ep_ovr_fifo.sv
module ep_ovr_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  // Storage has no reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/ep_ovr_classify.sv
module ep_ovr_classify
  import ep_ovr_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_eop,
  input  logic [LEN_W-1:0] max_pkt,
  input  logic             host_mode,
  input  logic             fifo_full,
  input  logic             dma_rdy,
  output logic             push,
  output logic             pkt_end,
  output pkt_outcome_e     outcome,
  output logic [LEN_W-1:0] final_len
);

  logic [LEN_W-1:0] stored_cnt;
  logic             lat_flag, ovr_flag;
  logic             lat_now, ovr_now, lat_any, ovr_any;

  // Room left in the buffer is judged on bytes already stored.
  assign ovr_now   = rx_valid && (stored_cnt >= max_pkt);
  // FIFO full and not draining this cycle.
  assign lat_now   = rx_valid && fifo_full && !dma_rdy;
  assign push      = rx_valid && !lat_flag && !lat_now && !ovr_now;
  assign pkt_end   = rx_valid && rx_eop;
  assign lat_any   = lat_flag || lat_now;
  assign ovr_any   = ovr_flag || ovr_now;
  assign final_len = stored_cnt + LEN_W'(push);

  always_comb begin
    if (lat_any)      outcome = host_mode ? OC_LAT_HOST : OC_LAT_DEV;
    else if (ovr_any) outcome = OC_OVERSIZE;
    else              outcome = OC_CLEAN;
  end

  always_ff @(posedge clk) begin
    if (rst || pkt_end) begin
      stored_cnt <= '0;
      lat_flag   <= 1'b0;
      ovr_flag   <= 1'b0;
    end else begin
      stored_cnt <= final_len;
      lat_flag   <= lat_any;
      ovr_flag   <= ovr_any;
    end
  end

endmodule

// File: rtl/ep_ovr_wb.sv
module ep_ovr_wb
  import ep_ovr_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int PID_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_end,
  input  pkt_outcome_e     outcome,
  input  logic [LEN_W-1:0] final_len,
  input  logic [PID_W-1:0] rx_pid,
  input  logic             int_en_tok,
  output logic             wb_req,
  output logic [PID_W-1:0] wb_pid,
  output logic [LEN_W-1:0] wb_len,
  output logic             tok_irq
);

  logic req_n;
  assign req_n = pkt_end && wants_writeback(outcome);

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_req  <= 1'b0;
      wb_pid  <= '0;
      wb_len  <= '0;
      tok_irq <= 1'b0;
    end else begin
      wb_req  <= req_n;
      tok_irq <= req_n && int_en_tok;
      if (req_n) begin
        wb_pid <= (outcome == OC_LAT_HOST) ? '1 : rx_pid;
        wb_len <= final_len;
      end
    end
  end

endmodule

// File: rtl/ep_ovr_status.sv
module ep_ovr_status
  import ep_ovr_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         pkt_end,
  input  pkt_outcome_e outcome,
  input  logic         clr_we,
  input  logic         clr_bit,
  input  logic         int_en_err,
  input  logic         err_en_dma,
  output logic         sts,
  output logic         err_irq
);

  logic set_ev, sts_n;

  assign set_ev = pkt_end && is_error(outcome);
  // Set dominates a same-cycle clear.
  assign sts_n  = set_ev || (sts && !(clr_we && clr_bit));

  always_ff @(posedge clk) begin
    if (rst) begin
      sts     <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      sts     <= sts_n;
      err_irq <= sts_n && int_en_err && err_en_dma;
    end
  end

endmodule

// File: rtl/ep_ovr_guard.sv
module ep_ovr_guard
  import ep_ovr_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LEN_W      = 11,
  parameter int PID_W      = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_eop,
  input  logic [PID_W-1:0]  rx_pid,
  input  logic [LEN_W-1:0]  max_pkt,
  input  logic              host_mode,
  input  logic              dma_rdy,
  output logic              dma_valid,
  output logic [DATA_W-1:0] dma_data,
  input  logic              int_en_tok,
  input  logic              int_en_err,
  input  logic              err_en_dma,
  input  logic              err_clr_we,
  input  logic              err_clr_bit,
  output logic              wb_req,
  output logic [PID_W-1:0]  wb_pid,
  output logic [LEN_W-1:0]  wb_len,
  output logic              tok_irq,
  output logic              err_irq,
  output logic              dma_err_sts
);

  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic             push, pop, empty, full, pkt_end;
  logic [CW-1:0]    fifo_cnt;
  logic [LEN_W-1:0] final_len;
  pkt_outcome_e     outcome;

  assign dma_valid = !empty;
  assign pop       = dma_valid && dma_rdy;

  ep_ovr_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(rx_data), .pop(pop),
    .dout(dma_data), .empty(empty), .full(full), .count(fifo_cnt)
  );

  ep_ovr_classify #(.LEN_W(LEN_W)) u_cls (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eop(rx_eop),
    .max_pkt(max_pkt), .host_mode(host_mode), .fifo_full(full),
    .dma_rdy(dma_rdy), .push(push), .pkt_end(pkt_end),
    .outcome(outcome), .final_len(final_len)
  );

  ep_ovr_wb #(.LEN_W(LEN_W), .PID_W(PID_W)) u_wb (
    .clk(clk), .rst(rst), .pkt_end(pkt_end), .outcome(outcome),
    .final_len(final_len), .rx_pid(rx_pid), .int_en_tok(int_en_tok),
    .wb_req(wb_req), .wb_pid(wb_pid), .wb_len(wb_len), .tok_irq(tok_irq)
  );

  ep_ovr_status u_sts (
    .clk(clk), .rst(rst), .pkt_end(pkt_end), .outcome(outcome),
    .clr_we(err_clr_we), .clr_bit(err_clr_bit), .int_en_err(int_en_err),
    .err_en_dma(err_en_dma), .sts(dma_err_sts), .err_irq(err_irq)
  );

endmodule

// File: rtl/ep_ovr_guard_chk.sv
module ep_ovr_guard_chk #(
  parameter int LEN_W = 11,
  parameter int PID_W = 4,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic             rx_eop,
  input logic [LEN_W-1:0] max_pkt,
  input logic             host_mode,
  input logic             dma_rdy,
  input logic             int_en_tok,
  input logic             int_en_err,
  input logic             err_en_dma,
  input logic             err_clr_we,
  input logic             err_clr_bit,
  input logic             wb_req,
  input logic [PID_W-1:0] wb_pid,
  input logic [LEN_W-1:0] wb_len,
  input logic             tok_irq,
  input logic             err_irq,
  input logic             dma_err_sts,
  input logic [CW-1:0]    fifo_cnt
);

  logic lat_eop;
  assign lat_eop = rx_valid && rx_eop && (fifo_cnt == CW'(DEPTH)) && !dma_rdy;

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(DEPTH));

  p_wb_after_eop_r11: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> $past(rx_valid && rx_eop));

  p_clip_r2: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> (wb_len <= $past(max_pkt)));

  p_lat_host_r5: assert property (@(posedge clk) disable iff (rst)
    (lat_eop && host_mode) |=> (wb_req && wb_pid == '1));

  p_lat_dev_r6: assert property (@(posedge clk) disable iff (rst)
    (lat_eop && !host_mode) |=> (!wb_req && dma_err_sts));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (dma_err_sts && !(err_clr_we && err_clr_bit)) |=> dma_err_sts);

  p_err_gate_r10: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> (dma_err_sts && $past(int_en_err && err_en_dma)));

  p_tok_gate_r10: assert property (@(posedge clk) disable iff (rst)
    tok_irq |-> (wb_req && $past(int_en_tok)));

endmodule

bind ep_ovr_guard ep_ovr_guard_chk #(
  .LEN_W(LEN_W), .PID_W(PID_W), .DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eop(rx_eop),
  .max_pkt(max_pkt), .host_mode(host_mode), .dma_rdy(dma_rdy),
  .int_en_tok(int_en_tok), .int_en_err(int_en_err), .err_en_dma(err_en_dma),
  .err_clr_we(err_clr_we), .err_clr_bit(err_clr_bit), .wb_req(wb_req),
  .wb_pid(wb_pid), .wb_len(wb_len), .tok_irq(tok_irq), .err_irq(err_irq),
  .dma_err_sts(dma_err_sts), .fifo_cnt(fifo_cnt)
);

// File: tb/sim_ep_ovr_guard.sv
`timescale 1ns/1ps
module sim_ep_ovr_guard;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0, rx_eop = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [3:0]  rx_pid = 4'h3;
  logic [10:0] max_pkt = 11'd8;
  logic        host_mode = 1'b1, dma_rdy = 1'b1;
  logic        dma_valid;
  logic [7:0]  dma_data;
  logic        int_en_tok = 1'b1, int_en_err = 1'b1, err_en_dma = 1'b1;
  logic        err_clr_we = 1'b0, err_clr_bit = 1'b0;
  logic        wb_req, tok_irq, err_irq, dma_err_sts;
  logic [3:0]  wb_pid;
  logic [10:0] wb_len;

  int checks = 0, fails = 0;
  int pop_cnt = 0, pop_base = 0, data_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ep_ovr_guard u0 (.*);

  // Memory-side monitor: bytes must leave in order 0x10, 0x11, ...
  always @(negedge clk) begin
    if (!rst && dma_valid && dma_rdy) begin
      if (dma_data != 8'(8'h10 + (pop_cnt - pop_base))) data_bad = data_bad + 1;
      pop_cnt = pop_cnt + 1;
    end
  end

  typedef struct packed {
    logic        host;
    logic [10:0] mp;
    logic [7:0]  nb;
    logic        rdy;
    logic        e_wb;
    logic [3:0]  e_pid;
    logic [10:0] e_len;
    logic        e_err;
    logic [7:0]  e_st;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 11'd8, 8'd5,  1'b1, 1'b1, 4'h3, 11'd5, 1'b0, 8'd5}, // R1 clean host
    '{1'b0, 11'd8, 8'd8,  1'b1, 1'b1, 4'h3, 11'd8, 1'b0, 8'd8}, // R1 exact fit
    '{1'b1, 11'd8, 8'd12, 1'b1, 1'b1, 4'h3, 11'd8, 1'b1, 8'd8}, // R2 R3 oversize host
    '{1'b0, 11'd4, 8'd9,  1'b1, 1'b1, 4'h3, 11'd4, 1'b1, 8'd4}, // R3 oversize device
    '{1'b1, 11'd8, 8'd7,  1'b0, 1'b1, 4'hF, 11'd4, 1'b1, 8'd4}, // R4 R5 latency host
    '{1'b0, 11'd8, 8'd7,  1'b0, 1'b0, 4'h0, 11'd0, 1'b1, 8'd4}, // R6 latency device
    '{1'b1, 11'd4, 8'd6,  1'b0, 1'b1, 4'hF, 11'd4, 1'b1, 8'd4}, // R7 both, host
    '{1'b0, 11'd4, 8'd6,  1'b0, 1'b0, 4'h0, 11'd0, 1'b1, 8'd4}, // R7 both, device
    '{1'b1, 11'd0, 8'd3,  1'b1, 1'b1, 4'h3, 11'd0, 1'b1, 8'd0}, // R2 zero max
    '{1'b0, 11'd1, 8'd1,  1'b1, 1'b1, 4'h3, 11'd1, 1'b0, 8'd1}, // R1 one byte
    '{1'b1, 11'd6, 8'd9,  1'b0, 1'b1, 4'hF, 11'd4, 1'b1, 8'd4}  // R4 latency before clip
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Sends bytes 0x10.. ; returns one cycle after the EOP edge.
  task automatic send(input int nb, input bit clr_on_eop);
    for (int i = 0; i < nb; i++) begin
      tick();
      rx_valid = 1'b1;
      rx_data  = 8'(8'h10 + i);
      rx_eop   = (i == nb - 1);
      if (clr_on_eop && i == nb - 1) begin
        err_clr_we = 1'b1; err_clr_bit = 1'b1;
      end
    end
    tick();
    rx_valid = 1'b0; rx_eop = 1'b0;
    err_clr_we = 1'b0; err_clr_bit = 1'b0;
  endtask

  task automatic clear_sts();
    tick(); err_clr_we = 1'b1; err_clr_bit = 1'b1;
    tick(); err_clr_we = 1'b0; err_clr_bit = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    // R11 reset state
    chk("R11 wb_req reset", wb_req, 0);
    chk("R11 dma_valid reset", dma_valid, 0);
    chk("R11 sts reset", dma_err_sts, 0);
    chk("R11 irq reset", {tok_irq, err_irq}, 0);
    rst = 1'b0;
    tick();

    for (int v = 0; v < NV; v++) begin
      string tg;
      vec_t t = VECS[v];
      if (!t.e_wb)              tg = "R6";
      else if (t.e_pid == 4'hF) tg = "R5";
      else if (t.e_err)         tg = "R3";
      else                      tg = "R1";
      clear_sts();
      host_mode = t.host; max_pkt = t.mp; dma_rdy = t.rdy;
      pop_base = pop_cnt; data_bad = 0;
      send(int'(t.nb), 1'b0);
      chk({tg, " wb_req"}, wb_req, int'(t.e_wb));
      if (t.e_wb) begin
        chk({tg, " wb_pid"}, wb_pid, int'(t.e_pid));
        chk({tg, " wb_len"}, wb_len, int'(t.e_len));
      end
      chk({tg, " R10 tok_irq"}, tok_irq, int'(t.e_wb));
      chk({tg, " R8 sts"}, dma_err_sts, int'(t.e_err));
      chk({tg, " R10 err_irq"}, err_irq, int'(t.e_err));
      tick();
      chk("R11 wb_req one cycle", wb_req, 0);
      dma_rdy = 1'b1;
      repeat (8) tick();
      chk("R2 R4 bytes stored", pop_cnt - pop_base, int'(t.e_st));
      chk("R1 byte order", data_bad, 0);
    end

    // R10 masks off: token and error interrupts suppressed
    clear_sts();
    int_en_tok = 1'b0; err_en_dma = 1'b0;
    host_mode = 1'b1; max_pkt = 11'd4; dma_rdy = 1'b1;
    send(6, 1'b0);
    chk("R10 wb with tok masked", wb_req, 1);
    chk("R10 tok_irq masked", tok_irq, 0);
    chk("R10 err_irq masked", err_irq, 0);
    chk("R8 sts while masked", dma_err_sts, 1);
    err_en_dma = 1'b1;
    tick();
    chk("R10 err_irq after unmask", err_irq, 1);
    int_en_err = 1'b0;
    tick();
    chk("R10 err_irq int_en_err off", err_irq, 0);
    int_en_err = 1'b1; int_en_tok = 1'b1;

    // R9 strobe with data 0 has no effect
    err_clr_we = 1'b1; err_clr_bit = 1'b0;
    tick();
    err_clr_we = 1'b0;
    tick();
    chk("R9 clear with bit 0 ignored", dma_err_sts, 1);
    chk("R8 sts held", err_irq, 1);
    // R9 clear
    err_clr_we = 1'b1; err_clr_bit = 1'b1;
    tick();
    err_clr_we = 1'b0; err_clr_bit = 1'b0;
    chk("R9 cleared", dma_err_sts, 0);
    chk("R9 err_irq after clear", err_irq, 0);
    // R9 set wins over same-cycle clear
    send(6, 1'b1);
    chk("R9 set wins", dma_err_sts, 1);
    repeat (8) tick();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule